// File: doc/BRIEF.md
# Four-Bank Memory Paging Unit

This block widens a 64 KiB processor address space to 1 MiB of physical memory. The two top address bits pick one of four 16 KiB banks. Each bank owns a page register that names a 16 KiB physical page. The unit drives the six high physical address lines, and it raises the flash or the SRAM chip select for the current memory request.

Software programs the unit through an 8-bit I/O write port. Each bank has a write-only page register. A separate global enable register turns paging on or off. While paging is off, the unit is in its boot mapping: every bank shows flash page 0 whatever the page registers hold. Boot code fills the page registers, keeping bank 0 on page 0, and then turns paging on.

The mode is held by a two-state machine. State `MODE_BOOT` is entered on reset and on the transition `disable`, which is a write to the enable register with data bit 0 equal to 0. State `MODE_PAGED` is entered on the transition `enable`, which is the same write with data bit 0 equal to 1. Any other cycle is the transition `hold`, and the state stays as it is.

Top module: `mpu_pager`

## Requirements
- R1: Bits 15:14 of `cpu_addr` pick the bank whose page register drives the outputs. Value 0 picks bank 0, and value 3 picks bank 3.
- R2: A write at port 78h+n (n = 0..3) loads the page register of bank n. A write at any port outside 78h..7Fh changes no page register and does not change the mode.
- R3: A write at any port from 7Ch to 7Fh sets the mode from data bit 0: 1 enables paging and 0 disables it. Data bits 7:1 of that write have no effect.
- R4: A write at ports 7Ch..7Fh never changes a page register.
- R5: After reset the unit is in the boot mapping. `pa_hi` is 0 for every bank, and a memory request selects flash.
- R6: While paging is off, `pa_hi` is 0 and a request selects flash, whatever the page registers hold.
- R7: While paging is on, with page register bit 6 equal to 0, `pa_hi` equals register bits 5:0. Bit 5 equal to 0 (pages 0..31) selects flash, and bit 5 equal to 1 (pages 32..63) selects SRAM.
- R8: While paging is on and the selected page register has bit 6 set, neither chip select is asserted.
- R9: Bit 7 of a page-register write has no effect on any output.
- R10: A chip select is asserted only while `mem_req` is 1, and the two chip selects are never asserted together.
- R11: A register write captured at a clock edge shows on the outputs right after that edge.
- R12: Turning paging off and then on again restores the earlier mapping, because the page registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, sampled at the rising edge |
| cpu_addr | input | 16 | CPU memory address |
| mem_req | input | 1 | Memory request |
| pa_hi | output | 6 | Physical address bits 19:14 |
| flash_sel | output | 1 | Flash chip select, active high |
| sram_sel | output | 1 | SRAM chip select, active high |

## Verification
The address translation and both chip selects are combinational. They settle in the same cycle as `cpu_addr` and `mem_req`, with no register on the path. A page or enable write is captured at one rising edge and is visible straight after it. The bench therefore holds the strobe over exactly one rising edge, releases it at the next falling edge, and samples the outputs 1 ns after each address change, with no strobe active. A sweep writes every 8-bit value to every bank and checks all four banks after each write. This shows that only the addressed register moved.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int IO_DATA_W = 8;
    localparam int IO_ADDR_W = 8;

    typedef enum logic {
        MODE_BOOT  = 1'b0,
        MODE_PAGED = 1'b1
    } mode_e;
endpackage

// File: rtl/mpu_io_decode.sv
module mpu_io_decode #(
    parameter int                                NUM_BANKS = 4,
    parameter logic [mpu_pkg::IO_ADDR_W-1:0]     IO_BASE   = 8'h78
) (
    input  logic [mpu_pkg::IO_ADDR_W-1:0] io_addr,
    input  logic                          io_wr,
    output logic [NUM_BANKS-1:0]          page_we,
    output logic                          mode_we
);
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int AW        = mpu_pkg::IO_ADDR_W;

    logic in_window;
    logic to_mode;

    // The window spans two groups of NUM_BANKS ports: page registers, then the enable register
    assign in_window = io_wr && (io_addr[AW-1:BANK_BITS+1] == IO_BASE[AW-1:BANK_BITS+1]);
    assign to_mode   = io_addr[BANK_BITS];
    assign mode_we   = in_window && to_mode;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign page_we[b] = in_window && !to_mode && (io_addr[BANK_BITS-1:0] == BANK_BITS'(b));
    end
endmodule

// File: rtl/mpu_bank_file.sv
module mpu_bank_file #(
    parameter int NUM_BANKS = 4,
    parameter int REG_BITS  = 7
) (
    input  logic                         clk,
    input  logic [NUM_BANKS-1:0]         page_we,
    input  logic [REG_BITS-1:0]          wdata,
    input  logic [$clog2(NUM_BANKS)-1:0] rd_bank,
    output logic [REG_BITS-1:0]          rd_page
);
    logic [REG_BITS-1:0] page_q [NUM_BANKS];

    // No reset: the boot mapping hides these registers until software loads them
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_reg
        always_ff @(posedge clk) begin
            if (page_we[b]) begin
                page_q[b] <= wdata;
            end
        end
    end

    assign rd_page = page_q[rd_bank];
endmodule

// File: rtl/mpu_mode_fsm.sv
module mpu_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic mode_bit,
    output logic paging_on
);
    import mpu_pkg::*;

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BOOT:  if (mode_we && mode_bit)  state_d = MODE_PAGED;
            MODE_PAGED: if (mode_we && !mode_bit) state_d = MODE_BOOT;
            default:    state_d = MODE_BOOT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_BOOT:  paging_on = 1'b0;
            MODE_PAGED: paging_on = 1'b1;
            default:    paging_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpu_pager.sv
module mpu_pager #(
    parameter int                            NUM_BANKS = 4,
    parameter int                            CPU_AW    = 16,
    parameter int                            PAGE_BITS = 6,
    parameter logic [mpu_pkg::IO_ADDR_W-1:0] IO_BASE   = 8'h78
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [mpu_pkg::IO_ADDR_W-1:0] io_addr,
    input  logic [mpu_pkg::IO_DATA_W-1:0] io_wdata,
    input  logic                          io_wr,
    input  logic [CPU_AW-1:0]             cpu_addr,
    input  logic                          mem_req,
    output logic [PAGE_BITS-1:0]          pa_hi,
    output logic                          flash_sel,
    output logic                          sram_sel
);
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int REG_BITS  = PAGE_BITS + 1;

    logic [NUM_BANKS-1:0] page_we;
    logic                 mode_we;
    logic                 paging_on;
    logic [BANK_BITS-1:0] bank;
    logic [REG_BITS-1:0]  cur_page;
    logic                 off_board;
    logic                 in_sram;
    logic                 unused_bits;

    assign bank = cpu_addr[CPU_AW-1:CPU_AW-BANK_BITS];

    mpu_io_decode #(.NUM_BANKS(NUM_BANKS), .IO_BASE(IO_BASE)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .page_we (page_we),
        .mode_we (mode_we)
    );

    mpu_bank_file #(.NUM_BANKS(NUM_BANKS), .REG_BITS(REG_BITS)) u_banks (
        .clk     (clk),
        .page_we (page_we),
        .wdata   (io_wdata[REG_BITS-1:0]),
        .rd_bank (bank),
        .rd_page (cur_page)
    );

    mpu_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_bit  (io_wdata[0]),
        .paging_on (paging_on)
    );

    // Bit above the page number marks an off-board page; the top page bit picks SRAM
    assign off_board = paging_on && cur_page[REG_BITS-1];
    assign in_sram   = paging_on && cur_page[PAGE_BITS-1];
    assign pa_hi     = paging_on ? cur_page[PAGE_BITS-1:0] : '0;
    assign flash_sel = mem_req && !off_board && !in_sram;
    assign sram_sel  = mem_req && !off_board && in_sram;

    assign unused_bits = ^{io_wdata[mpu_pkg::IO_DATA_W-1:REG_BITS], cpu_addr[CPU_AW-BANK_BITS-1:0]};
endmodule

// File: rtl/mpu_pager_chk.sv
module mpu_pager_chk #(
    parameter int                            NUM_BANKS = 4,
    parameter int                            PAGE_BITS = 6,
    parameter logic [mpu_pkg::IO_ADDR_W-1:0] IO_BASE   = 8'h78
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [mpu_pkg::IO_ADDR_W-1:0] io_addr,
    input logic [mpu_pkg::IO_DATA_W-1:0] io_wdata,
    input logic                          io_wr,
    input logic                          mem_req,
    input logic [PAGE_BITS-1:0]          pa_hi,
    input logic                          flash_sel,
    input logic                          sram_sel
);
    localparam int                            BANK_BITS = $clog2(NUM_BANKS);
    localparam int                            AW        = mpu_pkg::IO_ADDR_W;
    localparam logic [mpu_pkg::IO_ADDR_W-1:0] ENA_PORT  = IO_BASE + NUM_BANKS;

    logic mode_off_wr;
    assign mode_off_wr = io_wr && !io_wdata[0] && (io_addr[AW-1:BANK_BITS] == ENA_PORT[AW-1:BANK_BITS]);

    assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_sel, sram_sel}));

    assert_no_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (!flash_sel && !sram_sel));

    assert_boot_after_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_off_wr |=> (pa_hi == '0 && (flash_sel || !mem_req)));

    assert_boot_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_hi == '0 && !sram_sel));

    assert_flash_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sel |-> !pa_hi[PAGE_BITS-1]);

    assert_sram_high_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> pa_hi[PAGE_BITS-1]);
endmodule

bind mpu_pager mpu_pager_chk #(.NUM_BANKS(NUM_BANKS), .PAGE_BITS(PAGE_BITS), .IO_BASE(IO_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_wr     (io_wr),
    .mem_req   (mem_req),
    .pa_hi     (pa_hi),
    .flash_sel (flash_sel),
    .sram_sel  (sram_sel)
);

// File: tb/test_mpu_pager.sv
module test_mpu_pager;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr;
    logic [15:0] cpu_addr;
    logic        mem_req;
    logic [5:0]  pa_hi;
    logic        flash_sel;
    logic        sram_sel;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [7:0]  bm [4];
    logic        paging = 1'b0;

    mpu_pager i_mpu_pager (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
        .cpu_addr(cpu_addr), .mem_req(mem_req), .pa_hi(pa_hi),
        .flash_sel(flash_sel), .sram_sel(sram_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic check_bank(input int b, input logic req, input string rq);
        logic [5:0] e_pa;
        logic       e_f;
        logic       e_s;
        logic [7:0] v;
        cpu_addr = {b[1:0], 14'(b * 4099 + n_checks * 37)};
        mem_req  = req;
        #1;
        v = bm[b];
        if (!paging) begin
            e_pa = 6'd0;
            e_f  = req;
            e_s  = 1'b0;
        end else begin
            e_pa = v[5:0];
            e_f  = req && !v[6] && !v[5];
            e_s  = req && !v[6] && v[5];
        end
        n_checks++;
        if (pa_hi !== e_pa || flash_sel !== e_f || sram_sel !== e_s) begin
            n_errors++;
            $display("FAIL %s bank %0d: actual pa=%0d f=%b s=%b, expected pa=%0d f=%b s=%b",
                     rq, b, pa_hi, flash_sel, sram_sel, e_pa, e_f, e_s);
        end
    endtask

    task automatic check_all(input string rq);
        for (int b = 0; b < 4; b++) check_bank(b, 1'b1, rq);
    endtask

    initial begin
        rst_n    = 1'b0;
        io_addr  = 8'h00;
        io_wdata = 8'h00;
        io_wr    = 1'b0;
        cpu_addr = 16'h0000;
        mem_req  = 1'b0;
        for (int b = 0; b < 4; b++) bm[b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: boot mapping after reset
        check_all("R5");

        // R6: registers loaded but paging still off
        io_write(8'h78, 8'h00); bm[0] = 8'h00;
        io_write(8'h79, 8'h25); bm[1] = 8'h25;
        io_write(8'h7A, 8'h3F); bm[2] = 8'h3F;
        io_write(8'h7B, 8'h4A); bm[3] = 8'h4A;
        check_all("R6");

        // R3: enable with bits 7:1 set too
        io_write(8'h7D, 8'hFF); paging = 1'b1;
        check_all("R3 enable");

        // R1/R11/R7/R8/R9: every value into every bank, all banks checked each time
        for (int b = 0; b < 4; b++) begin
            for (int v = 0; v < 256; v++) begin
                io_write(8'h78 + 8'(b), 8'(v));
                bm[b] = 8'(v);
                if (v[6])      check_all("R8 R1 R11");
                else if (v[7]) check_all("R9 R1 R11");
                else           check_all("R7 R1 R11");
            end
        end

        // Distinct setup for later checks
        io_write(8'h78, 8'h00); bm[0] = 8'h00;
        io_write(8'h79, 8'h21); bm[1] = 8'h21;
        io_write(8'h7A, 8'h1E); bm[2] = 8'h1E;
        io_write(8'h7B, 8'h3F); bm[3] = 8'h3F;
        check_all("R7");

        // R4: enable-register writes leave page registers intact
        io_write(8'h7C, 8'h81);
        check_all("R4");
        io_write(8'h7F, 8'h55);
        check_all("R4");

        // R2: writes outside the window have no effect
        io_write(8'h77, 8'h00);
        io_write(8'h80, 8'h00);
        io_write(8'h38, 8'h7F);
        io_write(8'hF8, 8'h40);
        io_write(8'h74, 8'h00);
        check_all("R2");

        // R10: no select without a request
        for (int b = 0; b < 4; b++) check_bank(b, 1'b0, "R10 paged");

        // R3: disable with bits 7:1 set
        io_write(8'h7E, 8'hFE); paging = 1'b0;
        check_all("R3 disable");
        for (int b = 0; b < 4; b++) check_bank(b, 1'b0, "R10 boot");

        // R3: bits 7:1 alone do not enable
        io_write(8'h7C, 8'h02);
        check_all("R3 bit0 only");

        // R12: re-enable restores the earlier mapping
        io_write(8'h7F, 8'h01); paging = 1'b1;
        check_all("R12");

        // R5: reset returns to boot mapping, registers keep hidden values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        paging = 1'b0;
        check_all("R5 rereset");

        finish_run();
    end
endmodule